// File: doc/BRIEF.md
# Parallel LCD Write-Cycle Sequencer

This block runs single write transfers on an 8080-style parallel bus to an LCD panel controller. A one-cycle start strobe starts a transfer. On that strobe the block captures an address/command-select word, a data word and four phase lengths. It then places the address on the bus and pulls the active-low chip select low. Next it pulses the active-low write enable and drives the data word. It releases chip select last. Each gap between these edges is a programmable number of internal clock cycles, and each programmed value is lengthened by one cycle.

The four phase lengths are: setup from address to chip select, setup from chip select to write enable, write-enable width, and hold from write enable to chip select release. They are 4-bit unsigned values, so every phase lasts 1 to 16 cycles. A busy flag covers the transfer. A one-cycle done pulse marks the cycle in which chip select returns high. A strobe that arrives while busy is ignored. The held copies of the phase lengths reset to 0, 0, 1 and 0 (address setup, write setup, write width, write hold). All outputs come straight from flops.

Top module: `lcd_wr_seq`

## Requirements
- R1: During and after reset, with no start, lcd_cs_n_o and lcd_we_n_o are 1 and lcd_data_oe_o, busy_o and done_o are 0.
- R2: Take the clock edge that accepts start as cycle 0. lcd_addr_o shows the captured address from cycle 0. lcd_cs_n_o goes low exactly cs_setup+1 cycles later.
- R3: lcd_we_n_o goes low exactly wr_setup+1 cycles after lcd_cs_n_o goes low.
- R4: lcd_we_n_o stays low for exactly wr_active+1 cycles, then returns high.
- R5: lcd_cs_n_o returns high exactly wr_hold+1 cycles after lcd_we_n_o returns high. lcd_we_n_o is never low while lcd_cs_n_o is high.
- R6: lcd_data_oe_o is 1 from the edge where lcd_we_n_o falls until the edge where lcd_cs_n_o rises. Throughout that span lcd_data_o holds the captured data word.
- R7: busy_o rises on cycle 0 and falls on the edge where lcd_cs_n_o rises. done_o is 1 for exactly that one cycle.
- R8: A start strobe sampled while a transfer is in progress is ignored, including in the final cycle before chip select is released. A start strobe sampled in the cycle where done_o is 1 is accepted.
- R9: addr_i and data_i are captured on the accepting edge. Later changes to them do not alter lcd_addr_o or lcd_data_o during the transfer.
- R10: The four phase-length inputs are sampled on the accepting edge. Later changes to them do not alter any phase length of the transfer.
- R11: Each phase-length input is 4-bit unsigned and 0 gives a one-cycle phase. A transfer therefore keeps busy_o high for cs_setup+wr_setup+wr_active+wr_hold+4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request strobe |
| addr_i | input | ADDR_W | Address / command-select value |
| data_i | input | DATA_W | Data word to write |
| cs_setup_i | input | T_W | Address-to-chip-select setup length minus one |
| wr_setup_i | input | T_W | Chip-select-to-write setup length minus one |
| wr_active_i | input | T_W | Write-enable width minus one |
| wr_hold_i | input | T_W | Write-release-to-chip-select hold length minus one |
| lcd_addr_o | output | ADDR_W | Bus address / command-select pin |
| lcd_cs_n_o | output | 1 | Active-low chip select |
| lcd_we_n_o | output | 1 | Active-low write enable |
| lcd_data_o | output | DATA_W | Bus data value |
| lcd_data_oe_o | output | 1 | Data drive enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same edge: the end of one transfer, when chip select rises and done pulses, and a new start strobe. The bench raises start in the last busy cycle and expects it to be ignored: busy must be 0 on the next sample. It also raises start in the done cycle and expects a back-to-back transfer, whose edges are predicted from that cycle. Mid-transfer start pulses, together with changing address, data and phase-length inputs, check that the captured values and phase lengths do not change.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CSSU = 3'd2,
    PH_WACT = 3'd3,
    PH_HOLD = 3'd4
  } wr_phase_e;

  function automatic logic ph_cs_low(input wr_phase_e p);
    return (p == PH_CSSU) || (p == PH_WACT) || (p == PH_HOLD);
  endfunction

  function automatic logic ph_bus_driven(input wr_phase_e p);
    return (p == PH_WACT) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/lcd_wr_phase_cnt.sv
module lcd_wr_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R11: a loaded value N yields N further cycles before zero
  a_r11_cnt_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));

  a_r11_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcd_wr_ctrl.sv
module lcd_wr_ctrl
  import lcd_wr_pkg::*;
#(
  parameter int T_W           = 4,
  parameter int DEF_WR_SETUP  = 0,
  parameter int DEF_WR_ACTIVE = 1,
  parameter int DEF_WR_HOLD   = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [T_W-1:0] cs_setup_i,
  input  logic [T_W-1:0] wr_setup_i,
  input  logic [T_W-1:0] wr_active_i,
  input  logic [T_W-1:0] wr_hold_i,
  input  logic           cnt_zero_i,
  output wr_phase_e      phase_o,
  output wr_phase_e      phase_nxt_o,
  output logic           accept_o,
  output logic           cnt_load_o,
  output logic [T_W-1:0] cnt_val_o
);

  localparam logic [T_W-1:0] RST_WS = T_W'(DEF_WR_SETUP);
  localparam logic [T_W-1:0] RST_WA = T_W'(DEF_WR_ACTIVE);
  localparam logic [T_W-1:0] RST_WH = T_W'(DEF_WR_HOLD);

  wr_phase_e      phase_q;
  wr_phase_e      phase_d;
  logic [T_W-1:0] t_ws_q, t_wa_q, t_wh_q;
  logic           accept;

  assign accept = start_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept)     phase_d = PH_ADDR;
      PH_ADDR: if (cnt_zero_i) phase_d = PH_CSSU;
      PH_CSSU: if (cnt_zero_i) phase_d = PH_WACT;
      PH_WACT: if (cnt_zero_i) phase_d = PH_HOLD;
      PH_HOLD: if (cnt_zero_i) phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_CSSU: cnt_val_o = t_ws_q;
      PH_WACT: cnt_val_o = t_wa_q;
      PH_HOLD: cnt_val_o = t_wh_q;
      default: cnt_val_o = cs_setup_i;
    endcase
  end

  assign cnt_load_o = accept ||
                      ((phase_q != PH_IDLE) && (phase_q != PH_HOLD) && cnt_zero_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      t_ws_q  <= RST_WS;
      t_wa_q  <= RST_WA;
      t_wh_q  <= RST_WH;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        t_ws_q <= wr_setup_i;
        t_wa_q <= wr_active_i;
        t_wh_q <= wr_hold_i;
      end
    end
  end

  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_d;
  assign accept_o    = accept;

  // R2: a transfer always opens with the address phase
  a_r2_addr_first: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_ADDR));

  // R10: held phase lengths do not move while a transfer runs
  a_r10_len_held: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |=> ($stable(t_ws_q) && $stable(t_wa_q) && $stable(t_wh_q)));

endmodule

// File: rtl/lcd_wr_pins.sv
module lcd_wr_pins
  import lcd_wr_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  wr_phase_e         phase_i,
  input  wr_phase_e         phase_nxt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      data_o    <= '0;
      cs_n_o    <= 1'b1;
      we_n_o    <= 1'b1;
      data_oe_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
      cs_n_o    <= !ph_cs_low(phase_nxt_i);
      we_n_o    <= (phase_nxt_i != PH_WACT);
      data_oe_o <= ph_bus_driven(phase_nxt_i);
      busy_o    <= (phase_nxt_i != PH_IDLE);
      done_o    <= (phase_i != PH_IDLE) && (phase_nxt_i == PH_IDLE);
    end
  end

  // R5: write strobe only inside chip select
  a_r5_we_in_cs: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |-> !cs_n_o);

  // R6: data driven as soon as write enable falls, and held steady
  a_r6_oe_at_we: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n_o) |-> data_oe_o);

  a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

  // R7: done is a single pulse at chip-select release
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_n_o && !busy_o && $past(busy_o) && $rose(cs_n_o)));

  // R9: address held through the transfer
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
  import lcd_wr_pkg::*;
#(
  parameter int ADDR_W        = 1,
  parameter int DATA_W        = 16,
  parameter int T_W           = 4,
  parameter int DEF_WR_SETUP  = 0,
  parameter int DEF_WR_ACTIVE = 1,
  parameter int DEF_WR_HOLD   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [T_W-1:0]    cs_setup_i,
  input  logic [T_W-1:0]    wr_setup_i,
  input  logic [T_W-1:0]    wr_active_i,
  input  logic [T_W-1:0]    wr_hold_i,
  output logic [ADDR_W-1:0] lcd_addr_o,
  output logic              lcd_cs_n_o,
  output logic              lcd_we_n_o,
  output logic [DATA_W-1:0] lcd_data_o,
  output logic              lcd_data_oe_o,
  output logic              busy_o,
  output logic              done_o
);

  wr_phase_e      phase;
  wr_phase_e      phase_nxt;
  logic           accept;
  logic           cnt_load;
  logic [T_W-1:0] cnt_val;
  logic           cnt_zero;

  lcd_wr_ctrl #(
    .T_W           (T_W),
    .DEF_WR_SETUP  (DEF_WR_SETUP),
    .DEF_WR_ACTIVE (DEF_WR_ACTIVE),
    .DEF_WR_HOLD   (DEF_WR_HOLD)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cs_setup_i  (cs_setup_i),
    .wr_setup_i  (wr_setup_i),
    .wr_active_i (wr_active_i),
    .wr_hold_i   (wr_hold_i),
    .cnt_zero_i  (cnt_zero),
    .phase_o     (phase),
    .phase_nxt_o (phase_nxt),
    .accept_o    (accept),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val)
  );

  lcd_wr_phase_cnt #(
    .CNT_W (T_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  lcd_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .phase_i     (phase),
    .phase_nxt_i (phase_nxt),
    .addr_o      (lcd_addr_o),
    .cs_n_o      (lcd_cs_n_o),
    .we_n_o      (lcd_we_n_o),
    .data_o      (lcd_data_o),
    .data_oe_o   (lcd_data_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // R8: a start while busy never restarts the address phase
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && phase != PH_IDLE && start_i) |=> (phase != PH_ADDR || $past(phase) == PH_ADDR));

endmodule

// File: tb/lcd_wr_seq_test.sv
module lcd_wr_seq_test;

  localparam int ADDR_W = 1;
  localparam int DATA_W = 16;
  localparam int T_W    = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [T_W-1:0]    cs_setup_i = '0, wr_setup_i = '0, wr_active_i = '0, wr_hold_i = '0;
  logic [ADDR_W-1:0] lcd_addr_o;
  logic              lcd_cs_n_o, lcd_we_n_o, lcd_data_oe_o, busy_o, done_o;
  logic [DATA_W-1:0] lcd_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lcd_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_W(T_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .cs_setup_i(cs_setup_i), .wr_setup_i(wr_setup_i),
    .wr_active_i(wr_active_i), .wr_hold_i(wr_hold_i),
    .lcd_addr_o(lcd_addr_o), .lcd_cs_n_o(lcd_cs_n_o), .lcd_we_n_o(lcd_we_n_o),
    .lcd_data_o(lcd_data_o), .lcd_data_oe_o(lcd_data_oe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; runs one transfer and returns at the negedge of its done cycle.
  task automatic xfer(input int cs, input int ws, input int wa, input int wh,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input bit tail_start);
    int lo_cs, lo_we, hi_we, hi_cs;
    lo_cs = cs + 1;
    lo_we = cs + ws + 2;
    hi_we = cs + ws + wa + 3;
    hi_cs = cs + ws + wa + wh + 4;
    start_i = 1'b1;
    addr_i = a;
    data_i = d;
    cs_setup_i = T_W'(cs);
    wr_setup_i = T_W'(ws);
    wr_active_i = T_W'(wa);
    wr_hold_i = T_W'(wh);
    for (int k = 0; k <= hi_cs; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(lcd_cs_n_o == !(k >= lo_cs && k < hi_cs), "R2 R5 R10 R11 cs_n",
          lcd_cs_n_o, !(k >= lo_cs && k < hi_cs));
      chk(lcd_we_n_o == !(k >= lo_we && k < hi_we), "R3 R4 R10 we_n",
          lcd_we_n_o, !(k >= lo_we && k < hi_we));
      chk(lcd_data_oe_o == (k >= lo_we && k < hi_cs), "R6 data_oe",
          lcd_data_oe_o, (k >= lo_we && k < hi_cs));
      if (k >= lo_we && k < hi_cs)
        chk(lcd_data_o == d, "R6 R9 data", lcd_data_o, d);
      chk(lcd_addr_o == a, "R2 R9 addr", lcd_addr_o, a);
      chk(busy_o == (k < hi_cs), "R7 R11 busy", busy_o, (k < hi_cs));
      chk(done_o == (k == hi_cs), "R7 done", done_o, (k == hi_cs));
      if (k < hi_cs) begin
        addr_i = ADDR_W'($urandom);
        data_i = DATA_W'($urandom);
        cs_setup_i = T_W'($urandom);
        wr_setup_i = T_W'($urandom);
        wr_active_i = T_W'($urandom);
        wr_hold_i = T_W'($urandom);
      end
      if (k < hi_cs - 1) start_i = 1'($urandom);
      else               start_i = tail_start && (k == hi_cs - 1);
    end
  endtask

  task automatic idle_chk();
    @(posedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0, "R8 busy after done", busy_o, 0);
    chk(lcd_cs_n_o == 1'b1, "R8 cs_n after done", lcd_cs_n_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lcd_cs_n_o == 1'b1, "R1 cs_n", lcd_cs_n_o, 1);
    chk(lcd_we_n_o == 1'b1, "R1 we_n", lcd_we_n_o, 1);
    chk(lcd_data_oe_o == 1'b0, "R1 oe", lcd_data_oe_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(lcd_cs_n_o == 1'b1 && busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

    xfer(0, 0, 1, 0, 1'b1, 16'hA55A, 1'b0);
    idle_chk();
    // R11: all-zero lengths give one-cycle phases
    xfer(0, 0, 0, 0, 1'b0, 16'h1234, 1'b0);
    idle_chk();
    xfer(15, 15, 15, 15, 1'b1, 16'hFFFF, 1'b1);
    idle_chk();
    for (int i = 0; i < 48; i++) begin
      bit tail;
      bit chain;
      tail  = (i % 3 == 0);
      chain = (i % 4 == 1) && !tail;
      xfer(i % 16, (i * 5 + 1) % 16, (i * 7 + 3) % 16, (i * 11 + 2) % 16,
           ADDR_W'(i), DATA_W'(i * 4099 + 17), tail);
      // R8: chained transfers start during the done cycle
      if (!chain) idle_chk();
    end
    idle_chk();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule